// File: doc/BRIEF.md
# I2C controller control-flag unit

This unit keeps the three software-visible control flags of an I2C controller: a stop request, an interrupt/attention flag and an acknowledge enable. Software changes them through two write ports. One port sets the flags it is given. The other clears the flags it is given. Each port writes a 1 to act on a flag and a 0 to leave it alone. A read port returns the current flag values.

The unit sits next to an existing bit and byte engine. The engine reports four things: each new protocol state code, each detected Stop condition, whether it is master or slave, and the kind of byte it has just received. From these the unit produces four outputs:
- the SCL low-hold request that suspends the transfer while the attention flag is up;
- the level to drive in the acknowledge slot;
- the Stop request in master mode;
- a one-cycle recovery pulse in slave mode.

The unit also tracks whether the slave side is currently addressed. It uses that state to decide whether a received slave data byte is acknowledged.

Top module: `twi_flag_ctrl`

## Requirements
- R1: After reset, all flags are 0, `ctl_rdata` is 0, and `scl_hold`, `ack_low`, `stop_req`, `recover_pulse` and `slv_addressed` are all 0. Asserting `rst_n` clears the flags at once, without waiting for a clock edge.
- R2: When `set_we` is high, a 1 in `set_wdata` bit 2 sets the acknowledge flag, a 1 in bit 3 sets the attention flag, and a 1 in bit 4 sets the stop flag. A 0 leaves the flag unchanged, and all other bits are ignored.
- R3: In master mode (`eng_master`=1), `stop_req` is high while the stop flag is 1. An `eng_stop_seen` pulse in master mode clears the stop flag on the next edge. It does this even when the same cycle also writes a set of the stop flag.
- R4: In slave mode (`eng_master`=0), a set stop flag never raises `stop_req`. Instead it raises `recover_pulse` for exactly one cycle and clears itself on the following edge.
- R5: A pulse on `eng_state_vld` sets the attention flag unless `eng_state` equals 8'hF8; that code leaves the flag unchanged. A hardware set in the same cycle as a software clear of the flag leaves the flag set.
- R6: Only a 1 in `clr_wdata` bit 3 (with `clr_we`) clears the attention flag. Stop conditions, idle cycles and other clear bits never clear it.
- R7: `scl_hold` is high exactly when the attention flag is 1 and `scl_low` is 1. While `scl_low` is 0, `scl_hold` stays low.
- R8: A 1 in `clr_wdata` bit 2 clears the acknowledge flag. If both ports target the same flag in one cycle, the clear wins. Clear bits 0, 1 and 4 to 7 change nothing, so the stop flag cannot be cleared through the clear port.
- R9: With the acknowledge flag at 1, `ack_low` is 1 (drive SDA low) in four cases, selected by `rx_kind`:
  - own slave address (`rx_kind`=1);
  - general call address (`rx_kind`=2) while `gc_en`=1;
  - master receiver data byte (`rx_kind`=3);
  - slave receiver data byte (`rx_kind`=4) while `slv_addressed`=1.
- R10: `ack_low` is 0 (NACK) whenever the acknowledge flag is 0. It is also 0 for a general call with `gc_en`=0, for a slave data byte while not addressed, and for `rx_kind`=0.
- R11: `slv_addressed` becomes 1 on the edge after an acknowledged own address or general call. It returns to 0 on the edge after `eng_stop_seen` or `recover_pulse`. A NACKed address leaves it at 0.
- R12: `ctl_rdata` shows the acknowledge flag at bit 2, the attention flag at bit 3 and the stop flag at bit 4, with every other bit 0. It reflects a write from the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we | input | 1 | Set-port write strobe |
| set_wdata | input | 8 | Set-port data, write-one-to-set |
| clr_we | input | 1 | Clear-port write strobe |
| clr_wdata | input | 8 | Clear-port data, write-one-to-clear |
| ctl_rdata | output | 8 | Current flag values |
| eng_state_vld | input | 1 | Engine entered a new state |
| eng_state | input | 8 | New protocol state code |
| eng_stop_seen | input | 1 | Stop condition detected on the bus |
| eng_master | input | 1 | 1 = master mode, 0 = slave mode |
| gc_en | input | 1 | General call answering enabled |
| rx_kind | input | 3 | Kind of byte awaiting the acknowledge slot |
| scl_low | input | 1 | SCL is in its LOW phase |
| scl_hold | output | 1 | Hold SCL low |
| ack_low | output | 1 | 1 = drive ACK (SDA low), 0 = NACK |
| stop_req | output | 1 | Request a Stop condition (master) |
| recover_pulse | output | 1 | Slave error recovery, one cycle |
| slv_addressed | output | 1 | Slave side currently addressed |

## Verification
Each flag is a single register that feeds both the read port and an engine-facing output. A flag stuck at the wrong value therefore shows up in the very next cycle in two places: in `ctl_rdata`, and as a missing or spurious SCL hold, Stop request or acknowledge. A wrong priority between set and clear is caught on the edge that resolves the conflict. Wrong addressed-slave state shows up at the next slave data byte, as an inverted `ack_low`.

// File: rtl/twi_flag_pkg.sv
package twi_flag_pkg;

  // Flag positions shared by the set port, the clear port and the read port
  localparam int AA_POS  = 2;
  localparam int SI_POS  = 3;
  localparam int STO_POS = 4;
  localparam int KIND_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    RX_NONE     = 3'd0,
    RX_OWN_ADDR = 3'd1,
    RX_GEN_CALL = 3'd2,
    RX_MST_DATA = 3'd3,
    RX_SLV_DATA = 3'd4
  } rx_kind_e;

  typedef struct packed {
    logic sto;
    logic si;
    logic aa;
  } flags_t;

endpackage

// File: rtl/twi_flag_bank.sv
module twi_flag_bank
  import twi_flag_pkg::*;
#(
  parameter int          CTL_W      = 8,
  parameter int          STATE_W    = 8,
  parameter logic [7:0]  IDLE_STATE = 8'hF8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic [CTL_W-1:0]   set_wdata,
  input  logic               clr_we,
  input  logic [CTL_W-1:0]   clr_wdata,
  input  logic               st_vld,
  input  logic [STATE_W-1:0] st_code,
  input  logic               stop_seen,
  input  logic               is_master,
  output flags_t             flags_q
);

  localparam logic [STATE_W-1:0] IDLE_CODE = STATE_W'(IDLE_STATE);

  logic set_aa, set_si, set_sto;
  logic clr_aa, clr_si;
  logic si_evt, sto_hw_clr;
  logic aa_en, si_en, sto_en;
  logic aa_d, si_d, sto_d;

  // Reserved bits of both ports are deliberately left unconnected
  logic unused_set_bits;
  logic unused_clr_bits;
  assign unused_set_bits = ^{set_wdata[AA_POS-1:0], set_wdata[CTL_W-1:STO_POS+1]};
  assign unused_clr_bits = ^{clr_wdata[AA_POS-1:0], clr_wdata[CTL_W-1:SI_POS+1]};

  always_comb begin
    set_aa  = set_we & set_wdata[AA_POS];
    set_si  = set_we & set_wdata[SI_POS];
    set_sto = set_we & set_wdata[STO_POS];
    clr_aa  = clr_we & clr_wdata[AA_POS];
    clr_si  = clr_we & clr_wdata[SI_POS];
    si_evt  = st_vld & (st_code != IDLE_CODE);
    // Bus stop in master mode, or self-clear after one cycle in slave mode
    sto_hw_clr = (stop_seen & is_master) | (flags_q.sto & ~is_master);
  end

  // Next-state: clear beats set for software; hardware event beats software clear
  always_comb begin
    aa_en = set_aa | clr_aa;
    aa_d  = clr_aa ? 1'b0 : 1'b1;

    si_en = si_evt | set_si | clr_si;
    if (si_evt)      si_d = 1'b1;
    else if (clr_si) si_d = 1'b0;
    else             si_d = 1'b1;

    sto_en = sto_hw_clr | set_sto;
    sto_d  = sto_hw_clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (aa_en)  flags_q.aa  <= aa_d;
      if (si_en)  flags_q.si  <= si_d;
      if (sto_en) flags_q.sto <= sto_d;
    end
  end

endmodule

// File: rtl/twi_ack_sel.sv
module twi_ack_sel
  import twi_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aa,
  input  logic              gc_en,
  input  logic [KIND_W-1:0] rx_kind,
  input  logic              stop_seen,
  input  logic              recover,
  output logic              ack_low,
  output logic              addressed_q
);

  logic addr_hit;
  logic addressed_en;
  logic addressed_d;

  always_comb begin
    unique case (rx_kind)
      RX_OWN_ADDR: ack_low = aa;
      RX_GEN_CALL: ack_low = aa & gc_en;
      RX_MST_DATA: ack_low = aa;
      RX_SLV_DATA: ack_low = aa & addressed_q;
      default:     ack_low = 1'b0;
    endcase
  end

  always_comb begin
    addr_hit     = ack_low & ((rx_kind == RX_OWN_ADDR) | (rx_kind == RX_GEN_CALL));
    addressed_en = stop_seen | recover | addr_hit;
    addressed_d  = ~(stop_seen | recover);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed_q <= 1'b0;
    end else if (addressed_en) begin
      addressed_q <= addressed_d;
    end
  end

endmodule

// File: rtl/twi_scl_gate.sv
module twi_scl_gate (
  input  logic si,
  input  logic sto,
  input  logic is_master,
  input  logic scl_low,
  output logic scl_hold,
  output logic stop_req,
  output logic recover
);

  always_comb begin
    scl_hold = si & scl_low;
    stop_req = sto & is_master;
    recover  = sto & ~is_master;
  end

endmodule

// File: rtl/twi_flag_ctrl.sv
module twi_flag_ctrl
  import twi_flag_pkg::*;
#(
  parameter int         CTL_W       = 8,
  parameter int         STATE_W     = 8,
  parameter logic [7:0] IDLE_STATE  = 8'hF8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic [CTL_W-1:0]   set_wdata,
  input  logic               clr_we,
  input  logic [CTL_W-1:0]   clr_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  input  logic               eng_state_vld,
  input  logic [STATE_W-1:0] eng_state,
  input  logic               eng_stop_seen,
  input  logic               eng_master,
  input  logic               gc_en,
  input  logic [KIND_W-1:0]  rx_kind,
  input  logic               scl_low,
  output logic               scl_hold,
  output logic               ack_low,
  output logic               stop_req,
  output logic               recover_pulse,
  output logic               slv_addressed
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  flags_t                 flags;

  // Assert asynchronously, release after SYNC_STAGES edges
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  twi_flag_bank #(
    .CTL_W      (CTL_W),
    .STATE_W    (STATE_W),
    .IDLE_STATE (IDLE_STATE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_we    (set_we),
    .set_wdata (set_wdata),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .st_vld    (eng_state_vld),
    .st_code   (eng_state),
    .stop_seen (eng_stop_seen),
    .is_master (eng_master),
    .flags_q   (flags)
  );

  twi_scl_gate u_gate (
    .si        (flags.si),
    .sto       (flags.sto),
    .is_master (eng_master),
    .scl_low   (scl_low),
    .scl_hold  (scl_hold),
    .stop_req  (stop_req),
    .recover   (recover_pulse)
  );

  twi_ack_sel u_ack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .aa          (flags.aa),
    .gc_en       (gc_en),
    .rx_kind     (rx_kind),
    .stop_seen   (eng_stop_seen),
    .recover     (recover_pulse),
    .ack_low     (ack_low),
    .addressed_q (slv_addressed)
  );

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[AA_POS]  = flags.aa;
    ctl_rdata[SI_POS]  = flags.si;
    ctl_rdata[STO_POS] = flags.sto;
  end

endmodule

// File: rtl/twi_flag_ctrl_chk.sv
module twi_flag_ctrl_chk
  import twi_flag_pkg::*;
#(
  parameter int         CTL_W      = 8,
  parameter int         STATE_W    = 8,
  parameter logic [7:0] IDLE_STATE = 8'hF8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               set_we,
  input logic [CTL_W-1:0]   set_wdata,
  input logic               clr_we,
  input logic [CTL_W-1:0]   clr_wdata,
  input logic [CTL_W-1:0]   ctl_rdata,
  input logic               eng_state_vld,
  input logic [STATE_W-1:0] eng_state,
  input logic               eng_stop_seen,
  input logic               eng_master,
  input logic               scl_low,
  input logic               scl_hold,
  input logic               ack_low,
  input logic               stop_req,
  input logic               recover_pulse,
  input logic               slv_addressed
);

  logic aa, si, sto;
  assign aa  = ctl_rdata[AA_POS];
  assign si  = ctl_rdata[SI_POS];
  assign sto = ctl_rdata[STO_POS];

  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_master && eng_stop_seen) |=> !sto);

  a_r4_slave_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sto && !eng_master) |=> !sto);

  a_r4_no_slave_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_master |-> !stop_req);

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    recover_pulse |=> !recover_pulse);

  a_r5_state_sets_si: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state_vld && eng_state != STATE_W'(IDLE_STATE)) |=> si);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state_vld && eng_state == STATE_W'(IDLE_STATE) && !si
     && !(set_we && set_wdata[SI_POS])) |=> !si);

  a_r6_si_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (si && !(clr_we && clr_wdata[SI_POS])) |=> si);

  a_r7_no_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_low |-> !scl_hold);

  a_r7_hold_when_si: assert property (@(posedge clk) disable iff (!rst_n)
    (si && scl_low) |-> scl_hold);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && set_wdata[AA_POS] && clr_we && clr_wdata[AA_POS]) |=> !aa);

  a_r10_nack_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !aa |-> !ack_low);

  a_r11_drop_address: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_stop_seen || recover_pulse) |=> !slv_addressed);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[AA_POS-1:0] == '0 && ctl_rdata[CTL_W-1:STO_POS+1] == '0);

endmodule

bind twi_flag_ctrl twi_flag_ctrl_chk #(
  .CTL_W      (CTL_W),
  .STATE_W    (STATE_W),
  .IDLE_STATE (IDLE_STATE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .set_we        (set_we),
  .set_wdata     (set_wdata),
  .clr_we        (clr_we),
  .clr_wdata     (clr_wdata),
  .ctl_rdata     (ctl_rdata),
  .eng_state_vld (eng_state_vld),
  .eng_state     (eng_state),
  .eng_stop_seen (eng_stop_seen),
  .eng_master    (eng_master),
  .scl_low       (scl_low),
  .scl_hold      (scl_hold),
  .ack_low       (ack_low),
  .stop_req      (stop_req),
  .recover_pulse (recover_pulse),
  .slv_addressed (slv_addressed)
);

// File: tb/sim_twi_flag_ctrl.sv
module sim_twi_flag_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       set_we, clr_we;
  logic [7:0] set_wdata, clr_wdata, ctl_rdata;
  logic       eng_state_vld, eng_stop_seen, eng_master, gc_en, scl_low;
  logic [7:0] eng_state;
  logic [2:0] rx_kind;
  logic       scl_hold, ack_low, stop_req, recover_pulse, slv_addressed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  twi_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_wdata(set_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .ctl_rdata(ctl_rdata),
    .eng_state_vld(eng_state_vld), .eng_state(eng_state),
    .eng_stop_seen(eng_stop_seen), .eng_master(eng_master),
    .gc_en(gc_en), .rx_kind(rx_kind), .scl_low(scl_low),
    .scl_hold(scl_hold), .ack_low(ack_low), .stop_req(stop_req),
    .recover_pulse(recover_pulse), .slv_addressed(slv_addressed)
  );

  typedef struct packed {
    logic       swe;
    logic [7:0] sd;
    logic       cwe;
    logic [7:0] cd;
    logic       sv;
    logic [7:0] sc;
    logic       stop;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 12;
  // Master mode throughout; expected value is ctl_rdata after the edge
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h04}, // R2 set AA
    '{1'b1, 8'h18, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h1C}, // R2 set SI, STO
    '{1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 8'h00, 1'b0, 8'h14}, // R6 clear SI
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 8'h1C}, // R5 state sets SI
    '{1'b0, 8'h00, 1'b1, 8'h08, 1'b1, 8'hF8, 1'b0, 8'h14}, // R5 F8 silent
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h04}, // R3 stop clears STO
    '{1'b1, 8'h04, 1'b1, 8'h04, 1'b0, 8'h00, 1'b0, 8'h00}, // R8 clear wins
    '{1'b1, 8'h1F, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h1C}, // R2 reserved set bits
    '{1'b0, 8'h00, 1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 8'h1C}, // R8 reserved clear bits
    '{1'b0, 8'h00, 1'b1, 8'h08, 1'b1, 8'h50, 1'b0, 8'h1C}, // R5 hw set beats clear
    '{1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h0C}, // R3 stop beats set
    '{1'b0, 8'h00, 1'b1, 8'hEC, 1'b0, 8'h00, 1'b0, 8'h00}  // R12 clear AA and SI
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    set_we = 1'b0; clr_we = 1'b0; eng_state_vld = 1'b0; eng_stop_seen = 1'b0;
    rx_kind = 3'd0;
  endtask

  task automatic wr_set(input logic [7:0] d);
    set_we = 1'b1; set_wdata = d; tick();
  endtask

  task automatic wr_clr(input logic [7:0] d);
    clr_we = 1'b1; clr_wdata = d; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_we = 1'b0; clr_we = 1'b0; set_wdata = '0; clr_wdata = '0;
    eng_state_vld = 1'b0; eng_state = '0; eng_stop_seen = 1'b0; eng_master = 1'b1;
    gc_en = 1'b0; rx_kind = 3'd0; scl_low = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 outs", {3'b0, scl_hold, ack_low, stop_req, recover_pulse, slv_addressed}, 8'h00);
    rst_n = 1'b1;
    repeat (3) tick();

    for (int i = 0; i < NV; i++) begin
      set_we = TBL[i].swe; set_wdata = TBL[i].sd;
      clr_we = TBL[i].cwe; clr_wdata = TBL[i].cd;
      eng_state_vld = TBL[i].sv; eng_state = TBL[i].sc;
      eng_stop_seen = TBL[i].stop;
      tick();
      chk($sformatf("R2/R3/R5/R6/R8/R12 row %0d", i), ctl_rdata, TBL[i].exp);
    end

    // R3 stop request in master mode
    wr_set(8'h10);
    chk("R3 stop_req", {7'b0, stop_req}, 8'h01);
    chk("R3 no recover", {7'b0, recover_pulse}, 8'h00);
    eng_stop_seen = 1'b1; tick();
    chk("R3 cleared", {ctl_rdata[7:1], stop_req}, 8'h00);

    // R4 slave recovery
    eng_master = 1'b0;
    wr_set(8'h10);
    chk("R4 sto visible", ctl_rdata, 8'h10);
    chk("R4 pulse/stop", {6'b0, recover_pulse, stop_req}, 8'h02);
    tick();
    chk("R4 self clear", {ctl_rdata[7:1], recover_pulse}, 8'h00);
    eng_master = 1'b1;

    // R7 SCL hold, R6 SI stickiness
    wr_set(8'h08);
    chk("R7 scl high", {7'b0, scl_hold}, 8'h00);
    scl_low = 1'b1; #1;
    chk("R7 scl low", {7'b0, scl_hold}, 8'h01);
    eng_stop_seen = 1'b1; tick();
    repeat (3) tick();
    wr_clr(8'h04);
    chk("R6 si kept", ctl_rdata, 8'h08);
    wr_clr(8'h08);
    chk("R7 released", {ctl_rdata[7:1], scl_hold}, 8'h00);
    scl_low = 1'b0;

    // R9 / R10 / R11 acknowledge choice
    wr_set(8'h04);
    rx_kind = 3'd1; #1;
    chk("R9 own addr", {7'b0, ack_low}, 8'h01);
    tick();
    chk("R11 addressed", {7'b0, slv_addressed}, 8'h01);
    rx_kind = 3'd4; #1;
    chk("R9 slave data", {7'b0, ack_low}, 8'h01);
    eng_stop_seen = 1'b1; tick();
    chk("R11 stop drops", {7'b0, slv_addressed}, 8'h00);
    rx_kind = 3'd4; #1;
    chk("R10 slave data unaddressed", {7'b0, ack_low}, 8'h00);
    rx_kind = 3'd2; gc_en = 1'b0; #1;
    chk("R10 gc disabled", {7'b0, ack_low}, 8'h00);
    tick();
    chk("R11 not addressed", {7'b0, slv_addressed}, 8'h00);
    rx_kind = 3'd2; gc_en = 1'b1; #1;
    chk("R9 gc enabled", {7'b0, ack_low}, 8'h01);
    tick();
    chk("R11 gc addressed", {7'b0, slv_addressed}, 8'h01);
    rx_kind = 3'd3; #1;
    chk("R9 master data", {7'b0, ack_low}, 8'h01);
    eng_master = 1'b0;
    wr_set(8'h10);
    tick();
    chk("R11 recover drops", {7'b0, slv_addressed}, 8'h00);
    eng_master = 1'b1;
    wr_clr(8'h04);
    rx_kind = 3'd3; #1;
    chk("R10 master data nack", {7'b0, ack_low}, 8'h00);
    rx_kind = 3'd1; #1;
    chk("R10 own addr nack", {7'b0, ack_low}, 8'h00);
    tick();
    chk("R11 nack no address", {7'b0, slv_addressed}, 8'h00);
    rx_kind = 3'd0; #1;
    chk("R10 none", {7'b0, ack_low}, 8'h00);

    // R1 asynchronous reset with flags set
    wr_set(8'h1C);
    chk("R12 all set", ctl_rdata, 8'h1C);
    #2 rst_n = 1'b0; #1;
    chk("R1 async clear", ctl_rdata, 8'h00);
    tick();
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule